// File: doc/BRIEF.md
# Tile Forward DCT (4x4, fixed point)

This block turns one 4x4 tile of signed 16-bit residual samples into sixteen integer transform coefficients using a separable fixed-point forward DCT. A tile is written in as four rows, one per handshake beat. Each sample is scaled up by sixteen, and a small bias is applied to the top-left sample. The tile then passes twice through one shared 1-D butterfly-and-multiply datapath: first down the columns and then, after a transpose, along the rows. The result leaves as four coefficient rows through a valid/ready port. Before output, every coefficient gets a final shift that divides by four with a one-unit offset.

The block is used in an encoder's residual path ahead of quantisation. A static mode input chooses the output layout: four packed 16-bit coefficients, or four 32-bit sign-extended coefficients. The values are the same in both layouts. The block takes one tile at a time: the load port stays closed from the fourth accepted row until the last coefficient row has been taken.

Top module: `tile_fdct4`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: A row is accepted on each clock edge where in_valid and in_ready are both 1. Lane k sits at in_row bits [16k+15:16k] and is column k. Rows arrive top to bottom. After the fourth row, in_ready stays 0 until the tile has been fully emitted, and in_ready and out_valid are never 1 together.
- R3: Every sample is multiplied by 16 with 16-bit wrap. When the raw top-left sample (row 0, column 0) is nonzero, 1 is added to its scaled value with 16-bit wrap. No other sample is biased.
- R4: One 1-D pass on inputs (v0,v1,v2,v3) first forms four 16-bit wrapped values: s=v0+v3, t=v1+v2, u=v1-v2, w=v0-v3. It then computes y0=(s+t)*11585 and y2=(s-t)*11585, with s±t taken at full 32-bit precision, and y1=w*15137+u*6270 and y3=w*6270-u*15137. Each y is reduced as (y+8192)>>>14 and then truncated to its low 16 bits, with no saturation.
- R5: The first pass runs on each column and gives four results indexed j. The second pass runs, for each j, on the four column results of index j, taken in column order. Output row m, lane j carries the second pass's result m for index j.
- R6: Every coefficient is output as (x+1)>>>2, where x+1 wraps at 16 bits.
- R7: With wide_mode=0, lane k of a row is at out_row bits [16k+15:16k] and bits [127:64] are 0. With wide_mode=1, lane k is at bits [32k+31:32k], sign-extended from 16 bits.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_row holds its value.
- R9: out_valid first rises eight clock cycles after the edge that accepts the fourth row. The rows leave in order 0 to 3, one per edge where out_ready is 1. in_ready returns on the cycle after the fourth row is taken.
- R10: in_valid and in_row are ignored while in_ready is 0, and the tile in flight is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample row is present |
| in_ready | output | 1 | The block can take a row |
| in_row | input | 64 | Four signed 16-bit samples, lane 0 in the low bits |
| wide_mode | input | 1 | 0: packed 16-bit coefficients, 1: 32-bit sign-extended coefficients |
| out_valid | output | 1 | A coefficient row is present |
| out_ready | input | 1 | The consumer takes the row |
| out_row | output | 128 | Four coefficients in the layout chosen by wide_mode |

## Verification
Every stage writes into stored tile state, so a fault in the prescale, butterfly, rounding or transpose shows up as wrong coefficient values in the same tile's output rows. It appears no later than the ninth cycle after the last row is loaded. A swapped read or write index shows up as coefficients in the wrong lane or the wrong row, which impulse tiles at each of the sixteen positions expose one at a time. A fault in the sequencing shows up at the handshake ports: the wrong first-beat latency, a load port that reopens early, or a row that changes under backpressure.

// File: rtl/fdct4_pkg.sv
`timescale 1ns/1ps
package fdct4_pkg;
  localparam int SW      = 16;          // sample and coefficient width
  localparam int LANES   = 4;           // tile edge length
  localparam int WW      = 32;          // widened output lane width
  localparam int PW      = 32;          // product width
  localparam int PRE_SH  = 4;           // input prescale shift
  localparam int RND_SH  = 14;          // fixed-point constant width
  localparam int FIN_SH  = 2;           // final divide shift
  localparam int IDXW    = $clog2(LANES);
  localparam int ROWW    = LANES * SW;
  localparam int OUTW    = LANES * WW;

  localparam logic signed [PW-1:0] K_MID = PW'(11585);
  localparam logic signed [PW-1:0] K_HI  = PW'(15137);
  localparam logic signed [PW-1:0] K_LO  = PW'(6270);
  localparam logic signed [PW:0]   RND_BIAS =
    {{(PW+1-RND_SH){1'b0}}, 1'b1, {(RND_SH-1){1'b0}}};

  typedef logic signed [SW-1:0] samp_t;
  typedef logic [LANES-1:0][SW-1:0] lane_vec_t;
  typedef enum logic [1:0] {PH_LOAD, PH_COLS, PH_ROWS, PH_EMIT} phase_t;

  // scale by 16 with wrap, optional one-unit bias for the corner sample
  function automatic samp_t prescale(samp_t x, logic corner);
    samp_t s;
    s = samp_t'(x <<< PRE_SH);
    if (corner && (x != '0)) s = s + samp_t'(1);
    return s;
  endfunction

  // rounding right shift by the constant width, then keep the low bits
  function automatic samp_t round_narrow(logic signed [PW-1:0] p);
    logic signed [PW:0] t;
    t = ($signed({p[PW-1], p}) + RND_BIAS) >>> RND_SH;
    return samp_t'(t);
  endfunction

  // offset-by-one divide by four
  function automatic samp_t final_adjust(samp_t x);
    samp_t t;
    t = x + samp_t'(1);
    return t >>> FIN_SH;
  endfunction
endpackage

// File: rtl/fdct4_seq.sv
`timescale 1ns/1ps
module fdct4_seq
  import fdct4_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            out_ready,
  output logic            in_ready,
  output logic            out_valid,
  output phase_t          phase,
  output logic [IDXW-1:0] idx,
  output logic            load_fire,
  output logic            load_done,
  output logic            emit_done
);
  logic   step, last_idx, emit_fire;
  phase_t phase_nx;

  assign in_ready  = (phase == PH_LOAD);
  assign out_valid = (phase == PH_EMIT);
  assign load_fire = in_ready && in_valid;
  assign emit_fire = out_valid && out_ready;
  assign last_idx  = (idx == IDXW'(LANES-1));
  assign step      = load_fire || emit_fire ||
                     (phase == PH_COLS) || (phase == PH_ROWS);
  assign load_done = load_fire && last_idx;
  assign emit_done = emit_fire && last_idx;

  always_comb begin
    case (phase)
      PH_LOAD: phase_nx = PH_COLS;
      PH_COLS: phase_nx = PH_ROWS;
      PH_ROWS: phase_nx = PH_EMIT;
      default: phase_nx = PH_LOAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_LOAD;
      idx   <= '0;
    end else if (step) begin
      idx <= last_idx ? '0 : idx + IDXW'(1);
      if (last_idx) phase <= phase_nx;
    end
  end
endmodule

// File: rtl/fdct4_bank.sv
`timescale 1ns/1ps
module fdct4_bank
  import fdct4_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  lane_vec_t       wr_vec,
  input  logic [IDXW-1:0] rd_idx,
  output lane_vec_t       rd_vec
);
  // rows are written whole, columns are read whole: the transpose
  // between passes comes from this addressing
  for (genvar r = 0; r < LANES; r++) begin : g_row
    lane_vec_t row_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                row_q <= '0;
      else if (wr_en && (wr_idx == IDXW'(r)))    row_q <= wr_vec;
    end
    assign rd_vec[r] = row_q[rd_idx];
  end
endmodule

// File: rtl/fdct4_pass.sv
`timescale 1ns/1ps
module fdct4_pass
  import fdct4_pkg::*;
(
  input  lane_vec_t vin,
  output lane_vec_t vout
);
  samp_t v0, v1, v2, v3;
  samp_t s_sum, t_sum, u_dif, w_dif;
  logic signed [PW-1:0] st_add, st_sub, y0, y1, y2, y3;

  assign v0 = samp_t'(vin[0]);
  assign v1 = samp_t'(vin[1]);
  assign v2 = samp_t'(vin[2]);
  assign v3 = samp_t'(vin[3]);

  // butterflies wrap at the sample width
  assign s_sum = v0 + v3;
  assign t_sum = v1 + v2;
  assign u_dif = v1 - v2;
  assign w_dif = v0 - v3;

  // the even sums are widened before the multiply
  assign st_add = PW'(s_sum) + PW'(t_sum);
  assign st_sub = PW'(s_sum) - PW'(t_sum);
  assign y0 = st_add * K_MID;
  assign y2 = st_sub * K_MID;
  assign y1 = PW'(w_dif) * K_HI + PW'(u_dif) * K_LO;
  assign y3 = PW'(w_dif) * K_LO - PW'(u_dif) * K_HI;

  assign vout[0] = round_narrow(y0);
  assign vout[1] = round_narrow(y1);
  assign vout[2] = round_narrow(y2);
  assign vout[3] = round_narrow(y3);
endmodule

// File: rtl/fdct4_fmt.sv
`timescale 1ns/1ps
module fdct4_fmt
  import fdct4_pkg::*;
(
  input  lane_vec_t        coef,
  input  logic             wide,
  output logic [OUTW-1:0]  row
);
  logic [OUTW-1:0] narrow_v, wide_v;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    samp_t adj;
    assign adj = final_adjust(samp_t'(coef[k]));
    assign narrow_v[k*SW +: SW] = adj;
    assign wide_v[k*WW +: WW]   = {{(WW-SW){adj[SW-1]}}, adj};
  end
  assign narrow_v[OUTW-1:ROWW] = '0;

  assign row = wide ? wide_v : narrow_v;
endmodule

// File: rtl/tile_fdct4.sv
`timescale 1ns/1ps
module tile_fdct4
  import fdct4_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [ROWW-1:0] in_row,
  input  logic            wide_mode,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OUTW-1:0] out_row
);
  phase_t          phase;
  logic [IDXW-1:0] idx;
  logic            load_fire, load_done, emit_done;
  lane_vec_t       pre_row, a_col, b_col, pass_in, pass_out, a_wr;
  logic            a_we, b_we;

  fdct4_seq u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .phase(phase), .idx(idx),
    .load_fire(load_fire), .load_done(load_done), .emit_done(emit_done)
  );

  // R3: prescale on the way in; lane 0 of row 0 is the biased corner
  for (genvar k = 0; k < LANES; k++) begin : g_pre
    if (k == 0) begin : g_corner
      assign pre_row[k] = prescale(samp_t'(in_row[k*SW +: SW]), idx == '0);
    end else begin : g_plain
      assign pre_row[k] = prescale(samp_t'(in_row[k*SW +: SW]), 1'b0);
    end
  end

  // bank A: loaded tile, later reused for second-pass results
  assign a_we = load_fire || (phase == PH_ROWS);
  assign a_wr = (phase == PH_ROWS) ? pass_out : pre_row;
  fdct4_bank u_bank_a (
    .clk(clk), .rst_n(rst_n), .wr_en(a_we), .wr_idx(idx), .wr_vec(a_wr),
    .rd_idx(idx), .rd_vec(a_col)
  );

  // bank B: first-pass results, written row-wise = transposed
  assign b_we = (phase == PH_COLS);
  fdct4_bank u_bank_b (
    .clk(clk), .rst_n(rst_n), .wr_en(b_we), .wr_idx(idx), .wr_vec(pass_out),
    .rd_idx(idx), .rd_vec(b_col)
  );

  // one datapath shared by both passes
  assign pass_in = (phase == PH_ROWS) ? b_col : a_col;
  fdct4_pass u_pass (.vin(pass_in), .vout(pass_out));

  // R6, R7: final shift and lane layout on the read side of bank A
  fdct4_fmt u_fmt (.coef(a_col), .wide(wide_mode), .row(out_row));
endmodule

// File: rtl/fdct4_checker.sv
`timescale 1ns/1ps
module fdct4_checker
  import fdct4_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic            wide_mode,
  input logic [OUTW-1:0] out_row,
  input logic            load_done,
  input logic            emit_done
);
  localparam int LAT  = 2 * LANES;
  localparam int GAPW = $clog2(LAT + 1) + 1;
  logic [GAPW-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n)                                        gap <= '0;
    else if (load_done)                                gap <= '0;
    else if (!out_valid && !in_ready && (gap != '1))   gap <= gap + GAPW'(1);
  end

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  // R2
  load_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !in_ready);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && ($stable(out_row) || !$stable(wide_mode))));
  // R9
  emit_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit_done |=> (in_ready && !out_valid));
  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (gap == GAPW'(LAT)));
  // R7
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !wide_mode) |-> (out_row[OUTW-1:ROWW] == '0));
  for (genvar k = 0; k < LANES; k++) begin : g_sx
    // R7
    wide_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && wide_mode) |->
        ((out_row[k*WW+WW-1 : k*WW+SW-1] == '0) ||
         (out_row[k*WW+WW-1 : k*WW+SW-1] == '1)));
  end
endmodule

bind tile_fdct4 fdct4_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .wide_mode(wide_mode), .out_row(out_row),
  .load_done(load_done), .emit_done(emit_done)
);

// File: tb/tile_fdct4_test.sv
`timescale 1ns/1ps
module tile_fdct4_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         wide_mode = 1'b0;
  logic         out_ready = 1'b0;
  logic [63:0]  in_row = '0;
  logic         in_ready, out_valid;
  logic [127:0] out_row;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  shortint tile [4][4];
  shortint expc [4][4];
  logic [31:0] lfsr = 32'h1357_9bdf;

  always #2.5 clk = ~clk;

  tile_fdct4 uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_row(in_row), .wide_mode(wide_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_row(out_row)
  );

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic shortint w16(int v);
    return shortint'(v);
  endfunction

  function automatic void xform(input shortint v[4], output shortint y[4]);
    int s, t, u, w;
    s = w16(v[0] + v[3]); t = w16(v[1] + v[2]);
    u = w16(v[1] - v[2]); w = w16(v[0] - v[3]);
    y[0] = w16(((s + t) * 11585 + 8192) >>> 14);
    y[2] = w16(((s - t) * 11585 + 8192) >>> 14);
    y[1] = w16((w * 15137 + u * 6270 + 8192) >>> 14);
    y[3] = w16((w * 6270 - u * 15137 + 8192) >>> 14);
  endfunction

  task automatic build_ref();
    shortint sc [4][4];
    shortint mid [4][4];
    shortint v [4];
    shortint y [4];
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) sc[r][c] = w16(tile[r][c] * 16);
    if (tile[0][0] != 0) sc[0][0] = w16(sc[0][0] + 1);
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) v[r] = sc[r][c];
      xform(v, y);
      for (int j = 0; j < 4; j++) mid[j][c] = y[j];
    end
    for (int j = 0; j < 4; j++) begin
      for (int c = 0; c < 4; c++) v[c] = mid[j][c];
      xform(v, y);
      for (int m = 0; m < 4; m++) expc[m][j] = shortint'(w16(y[m] + 1) >>> 2);
    end
  endtask

  function automatic logic [127:0] exp_row(int m, logic wide);
    logic [127:0] r;
    int e;
    r = '0;
    for (int k = 0; k < 4; k++) begin
      e = expc[m][k];
      if (wide) r[k*32 +: 32] = e;
      else      r[k*16 +: 16] = e[15:0];
    end
    return r;
  endfunction

  task automatic run_tile(string req, logic wide, int stall, bit junk);
    int n;
    logic [127:0] held;
    build_ref();
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      wide_mode = wide;
      in_valid  = 1'b1;
      in_row    = {tile[r][3], tile[r][2], tile[r][1], tile[r][0]};
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    n = 1;
    in_valid = junk;
    in_row   = junk ? 64'h7fff_8000_1234_fedc : '0;
    check("R2 load closed after fourth row", {127'd0, in_ready}, 128'd0);
    while (!out_valid && n < 40) begin
      @(negedge clk);
      n++;
    end
    in_valid = 1'b0;
    check("R9 first beat latency", n, 9);
    for (int m = 0; m < 4; m++) begin
      check("R9 back-to-back beat", {127'd0, out_valid}, 128'd1);
      if (stall > 0) begin
        out_ready = 1'b0;
        held = out_row;
        for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          check("R8 held under stall", {out_valid, out_row[126:0]},
                {1'b1, held[126:0]});
        end
      end
      out_ready = 1'b1;
      check(req, out_row, exp_row(m, wide));
      @(posedge clk);
      @(negedge clk);
    end
    check("R9 load reopens", {126'd0, in_ready, out_valid}, 128'd2);
  endtask

  task automatic clear_tile();
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) tile[r][c] = 0;
  endtask

  function automatic shortint next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return shortint'(lfsr[15:0]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    shortint amps [5];
    amps = '{1, -1, 7, -300, 2047};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 reset state", {126'd0, in_ready, out_valid}, 128'd2);

    // R3: zero tile gets no bias
    clear_tile();
    run_tile("R3 zero tile", 1'b0, 0, 0);
    // R3 and R6: corner sample sweep
    for (int v = -8; v <= 8; v++) begin
      clear_tile();
      tile[0][0] = shortint'(v);
      run_tile("R3 R6 corner bias", v[0], 0, 0);
    end
    // R5: impulse at every position
    for (int p = 0; p < 16; p++)
      for (int a = 0; a < 5; a++) begin
        clear_tile();
        tile[p / 4][p % 4] = amps[a];
        run_tile("R5 impulse order", a[0], 0, 0);
      end
    // R4: flat tiles and wrapping extremes
    for (int a = 0; a < 5; a++) begin
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++) tile[r][c] = amps[a];
      run_tile("R4 flat tile", 1'b0, 0, 0);
    end
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) tile[r][c] = 16'sh7fff;
    run_tile("R4 wrap positive", 1'b1, 0, 0);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        tile[r][c] = ((r + c) % 2 == 0) ? 16'sh8000 : 16'sh7fff;
    run_tile("R4 wrap checker", 1'b0, 0, 0);
    // R7: same tile in both layouts
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) tile[r][c] = shortint'(-37 * (r + 1) + 11 * c);
    run_tile("R7 narrow layout", 1'b0, 0, 0);
    run_tile("R7 wide layout", 1'b1, 0, 0);
    // R8 R10: random tiles with stalls and junk on the load port
    for (int t = 0; t < 48; t++) begin
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++) begin
          tile[r][c] = next_rand();
          if (t % 3 == 0) tile[r][c] = tile[r][c] >>> 6;
        end
      run_tile("R10 R8 random tile", t[0], t % 3, t[1]);
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule